// File: doc/BRIEF.md
# Page-Mode DRAM Access Controller

This block connects a simple synchronous request port to a DRAM device whose row and column addresses take turns on one shared address bus. A client raises `req_valid` with a direction, a full word address and write data. The controller takes the request on a clock edge where `req_ready` is high. It splits the address into a row part (upper bits) and a column part (lower bits). It pulls the row strobe low with the row on the bus. After a programmable delay it pulls the column strobe low with the column on the bus, and it gates write-enable or output-enable for the access. A read returns its data on `rsp_rdata` together with a single-cycle `rsp_valid` pulse.

The row is left open once an access completes. A later request to that same row takes a short path: the controller strobes only a new column and does not activate the row again. A request to a different row first closes the open row and keeps the row strobe high for the precharge time. A refresh timer marks a refresh as due at a fixed interval, chosen so that every row is visited within the device retention window. Pending refreshes beat new requests. The controller closes any open row, then performs a row-strobe-only cycle on the next row from an internal refresh counter.

Top module: `dram_page_ctrl`

## Requirements
- R1: After reset, all four device strobes (row, column, write-enable, output-enable) are high (inactive), the write-data drive flag is low, `rsp_valid` is low and `req_ready` is high.
- R2: The row part of a request is `req_addr[ROW_W+COL_W-1:COL_W]`. The column part is `req_addr[COL_W-1:0]`. Each is presented zero-extended on `dram_addr`: the row while the row strobe is low and the column strobe is high during activation, and the column while the column strobe is low.
- R3: When a request is accepted with no row open, the row strobe falls on the next edge. The column strobe then falls exactly T_RCD cycles later.
- R4: During a write, the column strobe stays low for T_CAS cycles. In those cycles write-enable is low, output-enable is high, the drive flag is high and `dram_wdata` equals the request data.
- R5: During a read, the column strobe stays low for T_CAS cycles with output-enable low and write-enable high. The device data present T_CAS cycles after the column strobe falls is returned on `rsp_rdata`, with `rsp_valid` high for exactly that one following cycle. Writes produce no `rsp_valid`.
- R6: When an access completes, the row strobe stays low and the column strobe returns high, so the row stays open.
- R7: A request whose row matches the open row is a page hit. Its column strobe falls on the edge after acceptance, and the row strobe does not rise.
- R8: A request to a different row while a row is open raises the row strobe for T_RP cycles. The new row is then activated with the R3 timing.
- R9: Between any rise and the next fall of the row strobe, it stays high for at least T_RP cycles.
- R10: A refresh becomes due every REF_INTERVAL cycles. It is a cycle in which the row strobe is low and the column strobe stays high. It uses a refresh row counter that starts at 0, increments by one per refresh and wraps from 2^ROW_W-1 to 0. With the port idle, consecutive refreshes are exactly REF_INTERVAL cycles apart.
- R11: While a refresh is due, `req_ready` is low. An open row is closed and precharged before the refresh, so the next request after it takes the full activation path.
- R12: The column strobe is never low while the row strobe is high. Write-enable and output-enable are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ROW_W+COL_W (28) | Word address, row part in the upper bits |
| req_wdata | input | DATA_W (16) | Write data |
| req_ready | output | 1 | Request taken on an edge where this and req_valid are high |
| rsp_valid | output | 1 | One-cycle read-data pulse |
| rsp_rdata | output | DATA_W (16) | Read data |
| dram_addr | output | max(ROW_W,COL_W) (14) | Shared row/column address bus |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_dq_drive | output | 1 | Controller drives dram_wdata onto the data pins |
| dram_wdata | output | DATA_W (16) | Data toward the device |
| dram_rdata | input | DATA_W (16) | Data from the device |

## Verification
The hardest case to reach from the ports is a refresh falling due while a row is open. The controller must then precharge first, and the next request to the same row must lose its page-hit status. The timer phase cannot be seen directly. The bench therefore waits for a completed row-strobe-only cycle, which fixes the phase. It then opens a row and stays idle until the next refresh. Row-counter wrap is reached by building the bench with a narrow row field and letting more refreshes than there are rows go by.

// File: rtl/dramc_pkg.sv
package dramc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ACT,
        ST_COL,
        ST_OPEN,
        ST_PRE,
        ST_REF
    } seq_state_e;

    typedef enum logic [1:0] {
        SEL_ROW,
        SEL_COL,
        SEL_REFRESH
    } addr_sel_e;

    typedef struct packed {
        logic ras_n;
        logic cas_n;
        logic we_n;
        logic oe_n;
    } strobe_t;

    localparam strobe_t STROBES_IDLE = '{ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1, oe_n: 1'b1};

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/dramc_refresh.sv
module dramc_refresh #(
    parameter int unsigned ROW_W        = 14,
    parameter int unsigned REF_INTERVAL = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ref_done,
    output logic             ref_pend,
    output logic [ROW_W-1:0] ref_row
);
    localparam int unsigned TW = (REF_INTERVAL > 2) ? $clog2(REF_INTERVAL) : 1;

    logic [TW-1:0] tmr;
    logic          tick;

    assign tick = (tmr == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            tmr      <= TW'(REF_INTERVAL - 1);
            ref_pend <= 1'b0;
            ref_row  <= '0;
        end else begin
            tmr <= tick ? TW'(REF_INTERVAL - 1) : tmr - 1'b1;
            if (tick) begin
                ref_pend <= 1'b1;
            end else if (ref_done) begin
                ref_pend <= 1'b0;
            end
            if (ref_done) begin
                ref_row <= ref_row + 1'b1;
            end
        end
    end

    // A new tick must never find the previous refresh still unserved.
    assert_refresh_in_window_R10: assert property (@(posedge clk) disable iff (rst)
        tick |-> !ref_pend);

endmodule

// File: rtl/dramc_datapath.sv
module dramc_datapath
    import dramc_pkg::*;
#(
    parameter int unsigned ROW_W  = 14,
    parameter int unsigned COL_W  = 14,
    parameter int unsigned DATA_W = 16
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic [ROW_W+COL_W-1:0]             req_addr,
    input  logic                               req_write,
    input  logic [DATA_W-1:0]                  req_wdata,
    input  logic                               load_full,
    input  logic                               load_col,
    input  logic                               cap_en,
    input  addr_sel_e                          addr_sel,
    input  logic [ROW_W-1:0]                   ref_row,
    input  logic [DATA_W-1:0]                  dram_rdata,
    output logic                               page_hit,
    output logic                               cur_write,
    output logic [max2(ROW_W, COL_W)-1:0]      dram_addr,
    output logic [DATA_W-1:0]                  dram_wdata,
    output logic [DATA_W-1:0]                  rsp_rdata
);
    logic [ROW_W-1:0]  in_row;
    logic [COL_W-1:0]  in_col;
    logic [ROW_W-1:0]  cur_row;
    logic [COL_W-1:0]  cur_col;
    logic [DATA_W-1:0] cur_wdata;

    assign in_row   = req_addr[ROW_W+COL_W-1:COL_W];
    assign in_col   = req_addr[COL_W-1:0];
    assign page_hit = (in_row == cur_row);

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_row   <= '0;
            cur_col   <= '0;
            cur_write <= 1'b0;
            cur_wdata <= '0;
            rsp_rdata <= '0;
        end else begin
            if (load_full) begin
                cur_row <= in_row;
            end
            if (load_full || load_col) begin
                cur_col   <= in_col;
                cur_write <= req_write;
                cur_wdata <= req_wdata;
            end
            if (cap_en) begin
                rsp_rdata <= dram_rdata;
            end
        end
    end

    always_comb begin
        dram_addr = '0;
        unique case (addr_sel)
            SEL_ROW:     dram_addr[ROW_W-1:0] = cur_row;
            SEL_COL:     dram_addr[COL_W-1:0] = cur_col;
            default:     dram_addr[ROW_W-1:0] = ref_row;
        endcase
    end

    assign dram_wdata = cur_wdata;

    // The latched column must not change while its column strobe is active.
    assert_col_held_R2: assert property (@(posedge clk) disable iff (rst)
        (addr_sel == SEL_COL) && $past(addr_sel == SEL_COL) |-> $stable(cur_col));

endmodule

// File: rtl/dramc_seq.sv
module dramc_seq
    import dramc_pkg::*;
#(
    parameter int unsigned T_RCD = 2,
    parameter int unsigned T_CAS = 2,
    parameter int unsigned T_RP  = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      req_valid,
    input  logic      page_hit,
    input  logic      cur_write,
    input  logic      ref_pend,
    output logic      req_ready,
    output logic      load_full,
    output logic      load_col,
    output logic      cap_en,
    output logic      ref_done,
    output addr_sel_e addr_sel,
    output logic      ras_n,
    output logic      cas_n,
    output logic      we_n,
    output logic      oe_n,
    output logic      dq_drive,
    output logic      rsp_valid
);
    localparam int unsigned REF_LEN = T_RCD + T_CAS;
    localparam int unsigned CW      = $clog2(max2(REF_LEN, T_RP) + 1);
    localparam int unsigned HW      = $clog2(T_RP + 1);

    seq_state_e state;
    logic [CW-1:0] cnt;
    logic          cnt_zero;
    logic          miss_pend;
    logic          accept;
    strobe_t       pins;

    assign cnt_zero = (cnt == '0);

    always_comb begin
        req_ready = ((state == ST_IDLE) || (state == ST_OPEN)) && !ref_pend;
        accept    = req_valid && req_ready;
        load_full = accept && ((state == ST_IDLE) || !page_hit);
        load_col  = accept && (state == ST_OPEN) && page_hit;
        cap_en    = (state == ST_COL) && cnt_zero && !cur_write;
        ref_done  = (state == ST_REF) && cnt_zero;

        pins     = STROBES_IDLE;
        addr_sel = SEL_ROW;
        dq_drive = 1'b0;
        unique case (state)
            ST_ACT, ST_OPEN: pins.ras_n = 1'b0;
            ST_COL: begin
                pins.ras_n = 1'b0;
                pins.cas_n = 1'b0;
                pins.we_n  = !cur_write;
                pins.oe_n  = cur_write;
                addr_sel   = SEL_COL;
                dq_drive   = cur_write;
            end
            ST_REF: begin
                pins.ras_n = 1'b0;
                addr_sel   = SEL_REFRESH;
            end
            default: ;
        endcase
        ras_n = pins.ras_n;
        cas_n = pins.cas_n;
        we_n  = pins.we_n;
        oe_n  = pins.oe_n;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            cnt       <= '0;
            miss_pend <= 1'b0;
            rsp_valid <= 1'b0;
        end else begin
            rsp_valid <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (ref_pend) begin
                        state <= ST_REF;
                        cnt   <= CW'(REF_LEN - 1);
                    end else if (accept) begin
                        state <= ST_ACT;
                        cnt   <= CW'(T_RCD - 1);
                    end
                end
                ST_ACT: begin
                    if (cnt_zero) begin
                        state <= ST_COL;
                        cnt   <= CW'(T_CAS - 1);
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                ST_COL: begin
                    if (cnt_zero) begin
                        state     <= ST_OPEN;
                        rsp_valid <= !cur_write;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                ST_OPEN: begin
                    if (ref_pend) begin
                        state <= ST_PRE;
                        cnt   <= CW'(T_RP - 1);
                    end else if (accept) begin
                        if (page_hit) begin
                            state <= ST_COL;
                            cnt   <= CW'(T_CAS - 1);
                        end else begin
                            state     <= ST_PRE;
                            cnt       <= CW'(T_RP - 1);
                            miss_pend <= 1'b1;
                        end
                    end
                end
                ST_PRE: begin
                    if (cnt_zero) begin
                        if (miss_pend) begin
                            state     <= ST_ACT;
                            cnt       <= CW'(T_RCD - 1);
                            miss_pend <= 1'b0;
                        end else if (ref_pend) begin
                            state <= ST_REF;
                            cnt   <= CW'(REF_LEN - 1);
                        end else begin
                            state <= ST_IDLE;
                        end
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                ST_REF: begin
                    if (cnt_zero) begin
                        state <= ST_PRE;
                        cnt   <= CW'(T_RP - 1);
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Count of consecutive high cycles on the row strobe, saturating at T_RP.
    logic [HW-1:0] hi_cnt;
    always_ff @(posedge clk) begin
        if (rst) begin
            hi_cnt <= HW'(T_RP);
        end else if (ras_n) begin
            if (hi_cnt != HW'(T_RP)) hi_cnt <= hi_cnt + 1'b1;
        end else begin
            hi_cnt <= '0;
        end
    end

    assert_precharge_gap_R9: assert property (@(posedge clk) disable iff (rst)
        $fell(ras_n) |-> (hi_cnt >= HW'(T_RP)));

    assert_cas_inside_ras_R12: assert property (@(posedge clk) disable iff (rst)
        !cas_n |-> !ras_n);

    assert_we_oe_exclusive_R12: assert property (@(posedge clk) disable iff (rst)
        !(!we_n && !oe_n));

    assert_rsp_single_pulse_R5: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);

    assert_hit_keeps_row_R7: assert property (@(posedge clk) disable iff (rst)
        load_col |=> (!ras_n && !cas_n));

endmodule

// File: rtl/dram_page_ctrl.sv
module dram_page_ctrl
    import dramc_pkg::*;
#(
    parameter int unsigned ROW_W        = 14,
    parameter int unsigned COL_W        = 14,
    parameter int unsigned DATA_W       = 16,
    parameter int unsigned T_RCD        = 2,
    parameter int unsigned T_CAS        = 2,
    parameter int unsigned T_RP         = 2,
    parameter int unsigned REF_INTERVAL = 24
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          req_valid,
    input  logic                          req_write,
    input  logic [ROW_W+COL_W-1:0]        req_addr,
    input  logic [DATA_W-1:0]             req_wdata,
    output logic                          req_ready,
    output logic                          rsp_valid,
    output logic [DATA_W-1:0]             rsp_rdata,
    output logic [max2(ROW_W, COL_W)-1:0] dram_addr,
    output logic                          dram_ras_n,
    output logic                          dram_cas_n,
    output logic                          dram_we_n,
    output logic                          dram_oe_n,
    output logic                          dram_dq_drive,
    output logic [DATA_W-1:0]             dram_wdata,
    input  logic [DATA_W-1:0]             dram_rdata
);
    logic             ref_pend;
    logic             ref_done;
    logic [ROW_W-1:0] ref_row;
    logic             page_hit;
    logic             cur_write;
    logic             load_full;
    logic             load_col;
    logic             cap_en;
    addr_sel_e        addr_sel;

    dramc_refresh #(
        .ROW_W        (ROW_W),
        .REF_INTERVAL (REF_INTERVAL)
    ) u_refresh (
        .clk      (clk),
        .rst      (rst),
        .ref_done (ref_done),
        .ref_pend (ref_pend),
        .ref_row  (ref_row)
    );

    dramc_datapath #(
        .ROW_W  (ROW_W),
        .COL_W  (COL_W),
        .DATA_W (DATA_W)
    ) u_datapath (
        .clk        (clk),
        .rst        (rst),
        .req_addr   (req_addr),
        .req_write  (req_write),
        .req_wdata  (req_wdata),
        .load_full  (load_full),
        .load_col   (load_col),
        .cap_en     (cap_en),
        .addr_sel   (addr_sel),
        .ref_row    (ref_row),
        .dram_rdata (dram_rdata),
        .page_hit   (page_hit),
        .cur_write  (cur_write),
        .dram_addr  (dram_addr),
        .dram_wdata (dram_wdata),
        .rsp_rdata  (rsp_rdata)
    );

    dramc_seq #(
        .T_RCD (T_RCD),
        .T_CAS (T_CAS),
        .T_RP  (T_RP)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .page_hit  (page_hit),
        .cur_write (cur_write),
        .ref_pend  (ref_pend),
        .req_ready (req_ready),
        .load_full (load_full),
        .load_col  (load_col),
        .cap_en    (cap_en),
        .ref_done  (ref_done),
        .addr_sel  (addr_sel),
        .ras_n     (dram_ras_n),
        .cas_n     (dram_cas_n),
        .we_n      (dram_we_n),
        .oe_n      (dram_oe_n),
        .dq_drive  (dram_dq_drive),
        .rsp_valid (rsp_valid)
    );

endmodule

// File: tb/test_dram_page_ctrl.sv
module test_dram_page_ctrl;
    localparam int ROW_W  = 4;
    localparam int COL_W  = 6;
    localparam int DW     = 16;
    localparam int AW     = (ROW_W > COL_W) ? ROW_W : COL_W;
    localparam int T_RCD  = 3;
    localparam int T_CAS  = 2;
    localparam int T_RP   = 2;
    localparam int REF_IV = 200;
    localparam int MEMN   = 1 << (ROW_W + COL_W);

    logic                   clk = 1'b0;
    logic                   rst = 1'b1;
    logic                   req_valid = 1'b0;
    logic                   req_write = 1'b0;
    logic [ROW_W+COL_W-1:0] req_addr = '0;
    logic [DW-1:0]          req_wdata = '0;
    logic                   req_ready;
    logic                   rsp_valid;
    logic [DW-1:0]          rsp_rdata;
    logic [AW-1:0]          dram_addr;
    logic                   dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n, dram_dq_drive;
    logic [DW-1:0]          dram_wdata;
    logic [DW-1:0]          dram_rdata;

    always #10 clk = ~clk;

    dram_page_ctrl #(
        .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DW),
        .T_RCD(T_RCD), .T_CAS(T_CAS), .T_RP(T_RP), .REF_INTERVAL(REF_IV)
    ) i_dram_page_ctrl (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_ready(req_ready),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .dram_addr(dram_addr), .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n),
        .dram_we_n(dram_we_n), .dram_oe_n(dram_oe_n), .dram_dq_drive(dram_dq_drive),
        .dram_wdata(dram_wdata), .dram_rdata(dram_rdata)
    );

    int checks = 0, fails = 0;
    int mon_checks = 0, mon_fails = 0;
    int wd_fail = 0;
    bit done = 1'b0;

    function automatic logic [DW-1:0] init_word(input int i);
        return DW'(16'h5A00 ^ (i * 37));
    endfunction

    // ---------------- device model and port monitor ----------------
    logic [DW-1:0]    mem [MEMN];
    logic [ROW_W-1:0] lat_row = '0;
    logic [COL_W-1:0] lat_col = '0;
    logic prev_ras = 1'b1, prev_cas = 1'b1, prev_ready = 1'b0;
    int   cyc = 0, ras_run = 1000;
    logic fall_prev_ready = 1'b0, cas_seen = 1'b0;
    logic [ROW_W-1:0] fall_row = '0;
    int   fall_gap = 0;
    int   ref_count = 0, ref_last_cyc = 0, ref_prev_cyc = 0, ref_last_gap = 0;
    logic [ROW_W-1:0] ref_last_row = '0, ref_prev_row = '0;

    initial begin
        for (int i = 0; i < MEMN; i++) mem[i] = init_word(i);
    end

    assign dram_rdata = mem[{lat_row, lat_col}];

    always @(negedge clk) begin
        cyc++;
        if (!rst) begin
            if (!dram_ras_n && prev_ras) begin
                lat_row         = dram_addr[ROW_W-1:0];
                fall_row        = dram_addr[ROW_W-1:0];
                fall_prev_ready = prev_ready;
                fall_gap        = ras_run;
                cas_seen        = 1'b0;
                mon_checks++;
                if (ras_run < T_RP) begin
                    mon_fails++;
                    $display("FAIL R9 precharge gap actual=%0d expected>=%0d", ras_run, T_RP);
                end
            end
            if (!dram_cas_n) cas_seen = 1'b1;
            if (!dram_cas_n && prev_cas) lat_col = dram_addr[COL_W-1:0];
            if (!dram_cas_n && !dram_we_n) mem[{lat_row, lat_col}] = dram_wdata;
            if (dram_ras_n && !prev_ras && !cas_seen) begin
                ref_count++;
                ref_prev_row = ref_last_row;
                ref_last_row = fall_row;
                ref_prev_cyc = ref_last_cyc;
                ref_last_cyc = cyc;
                ref_last_gap = fall_gap;
                mon_checks++;
                if (fall_prev_ready !== 1'b0) begin
                    mon_fails++;
                    $display("FAIL R11 ready before refresh actual=%0b expected=0", fall_prev_ready);
                end
            end
        end
        if (dram_ras_n) ras_run++; else ras_run = 0;
        prev_ras   = dram_ras_n;
        prev_cas   = dram_cas_n;
        prev_ready = req_ready;
    end

    // ---------------- helpers ----------------
    task automatic chk(input bit ok, input string rq, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    task automatic wait_after_refresh();
        int n0;
        n0 = ref_count;
        while (ref_count == n0) @(negedge clk);
        while (!req_ready) @(negedge clk);
    endtask

    // Issues one request and checks every port cycle until the response cycle.
    task automatic run_access(input logic wr, input logic [ROW_W-1:0] row,
                              input logic [COL_W-1:0] col, input logic [DW-1:0] wd,
                              input int npre, input int nact, output logic [DW-1:0] rd);
        int last;
        logic [5:0] got, exp;
        string rq;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = {row, col}; req_wdata = wd;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        last = npre + nact + T_CAS + 1;
        rd = '0;
        for (int c = 1; c <= last; c++) begin
            got = {dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n, dram_dq_drive, rsp_valid};
            if (c <= npre) begin
                exp = 6'b111100; rq = "R8";
            end else if (c <= npre + nact) begin
                exp = 6'b011100; rq = "R3";
                chk(dram_addr == AW'(row), "R2", "row on bus", dram_addr, AW'(row));
            end else if (c <= npre + nact + T_CAS) begin
                exp = {1'b0, 1'b0, !wr, wr, wr, 1'b0}; rq = wr ? "R4" : "R5";
                chk(dram_addr == AW'(col), "R2", "column on bus", dram_addr, AW'(col));
                if (wr) chk(dram_wdata == wd, "R4", "write data", dram_wdata, wd);
            end else begin
                exp = {1'b0, 1'b1, 1'b1, 1'b1, 1'b0, !wr}; rq = "R6";
                rd = rsp_rdata;
            end
            chk(got == exp, rq, $sformatf("strobes cycle %0d", c), got, exp);
            if (c != last) @(negedge clk);
        end
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        chk({dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n} == 4'hF, "R1", "strobes",
            {dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n}, 4'hF);
        chk(dram_dq_drive == 1'b0, "R1", "drive", dram_dq_drive, 0);
        chk(rsp_valid == 1'b0, "R1", "rsp_valid", rsp_valid, 0);
        chk(req_ready == 1'b1, "R1", "ready", req_ready, 1);
    endtask

    task automatic t_miss_then_hit();
        logic [DW-1:0] rd;
        wait_after_refresh();
        run_access(1'b1, 4'd3, 6'd10, 16'h1234, 0, T_RCD, rd);      // R3 R4 from idle
        run_access(1'b0, 4'd3, 6'd10, 16'h0, 0, 0, rd);             // R7 hit read
        chk(rd == 16'h1234, "R5", "read back", rd, 16'h1234);
    endtask

    task automatic t_page_hits();
        logic [DW-1:0] rd;
        run_access(1'b1, 4'd3, 6'd11, 16'hBEEF, 0, 0, rd);          // R7 hit write
        run_access(1'b0, 4'd3, 6'd12, 16'h0, 0, 0, rd);             // R7 hit read, unwritten
        chk(rd == init_word({4'd3, 6'd12}), "R5", "unwritten word", rd, init_word({4'd3, 6'd12}));
        run_access(1'b0, 4'd3, 6'd11, 16'h0, 0, 0, rd);
        chk(rd == 16'hBEEF, "R7", "hit read back", rd, 16'hBEEF);
        repeat (3) @(negedge clk);
        chk({dram_ras_n, dram_cas_n, rsp_valid} == 3'b010, "R6", "row kept open while idle",
            {dram_ras_n, dram_cas_n, rsp_valid}, 3'b010);
    endtask

    task automatic t_page_miss();
        logic [DW-1:0] rd;
        run_access(1'b0, 4'd9, 6'd5, 16'h0, T_RP, T_RCD, rd);       // R8 miss from open row
        chk(rd == init_word({4'd9, 6'd5}), "R8", "miss read data", rd, init_word({4'd9, 6'd5}));
        run_access(1'b1, 4'd9, 6'd63, 16'h0F0F, 0, 0, rd);
        run_access(1'b0, 4'd3, 6'd10, 16'h0, T_RP, T_RCD, rd);
        chk(rd == 16'h1234, "R8", "back to first row", rd, 16'h1234);
        run_access(1'b0, 4'd9, 6'd63, 16'h0, T_RP, T_RCD, rd);
        chk(rd == 16'h0F0F, "R2", "top column", rd, 16'h0F0F);
    endtask

    task automatic t_refresh_closes_row();
        logic [DW-1:0] rd;
        int n0;
        wait_after_refresh();
        run_access(1'b0, 4'd5, 6'd1, 16'h0, 0, T_RCD, rd);
        n0 = ref_count;
        while (ref_count == n0) @(negedge clk);
        chk(ref_last_gap >= T_RP, "R11", "precharge before refresh", ref_last_gap, T_RP);
        run_access(1'b0, 4'd5, 6'd1, 16'h0, 0, T_RCD, rd);          // row no longer open
        chk(rd == init_word({4'd5, 6'd1}), "R11", "read after refresh", rd, init_word({4'd5, 6'd1}));
    endtask

    task automatic t_refresh_cadence();
        int n0;
        wait_after_refresh();
        n0 = ref_count;
        while (ref_count < n0 + 2) @(negedge clk);
        chk(ref_last_cyc - ref_prev_cyc == REF_IV, "R10", "refresh spacing",
            ref_last_cyc - ref_prev_cyc, REF_IV);
        chk(ref_last_row == ref_prev_row + 1'b1, "R10", "refresh row step",
            ref_last_row, ref_prev_row + 1'b1);
    endtask

    task automatic t_refresh_wrap();
        int n0;
        bit wrapped = 1'b0;
        bit steps_ok = 1'b1;
        for (int k = 0; k < (1 << ROW_W) + 1; k++) begin
            n0 = ref_count;
            while (ref_count == n0) @(negedge clk);
            if (ref_last_row != ref_prev_row + 1'b1) steps_ok = 1'b0;
            if (ref_prev_row == '1 && ref_last_row == '0) wrapped = 1'b1;
        end
        chk(steps_ok, "R10", "consecutive refresh rows", steps_ok, 1);
        chk(wrapped, "R10", "refresh row wrap", wrapped, 1);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_miss_then_hit();
        t_page_hits();
        t_page_miss();
        t_refresh_closes_row();
        t_refresh_cadence();
        t_refresh_wrap();
        repeat (5) @(negedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***",
                 checks + mon_checks, fails + mon_fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            wd_fail = 1;
            $display("FAIL watchdog all actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***",
                     checks + mon_checks + 1, fails + mon_fails + wd_fail);
            $finish;
        end
    end

endmodule